// File: doc/BRIEF.md
# Pseudo-Static RAM Behavioural Device Model

This block is a clocked, synthesizable stand-in for a small pseudo-static RAM with a 16-bit word split into an upper and a lower byte lane. On every rising clock edge it samples two chip selects (one active-low, one active-high), an active-low output enable, an active-low write enable and two active-low byte-lane selects. From these it performs byte-lane reads and writes on a parameterised internal array. Read data leaves on a separate output word with one drive-enable bit per lane, so a chip-level wrapper can build the tri-state bus.

The model follows the device life cycle seen from outside. After reset, a start-up timer keeps the part unavailable for a fixed number of cycles. After that, a hidden refresh scheduler refreshes the storage only while the chip is deselected. If selection is held so long that refresh cannot run in time, the scheduler raises a sticky data-loss flag. A system model uses the block to check that its controller leaves deselect gaps often enough and long enough.

Top module: `psram_model`

## Requirements
- R1: The chip counts as selected only when `sel_n` is 0 and `sel_hi` is 1. On any edge that samples the chip deselected, both bits of `dq_oe` are 0 after that edge and no write is started.
- R2: A read is sampled when the chip is selected, `we_n` is 1 and `oe_n` is 0. After that edge, `dq_oe[1]` (bits 15:8) is 1 exactly when `ub_n` was 0, and `dq_oe[0]` (bits 7:0) is 1 exactly when `lb_n` was 0. The enabled lanes of `dq_out` carry the stored word at `addr`. With `oe_n` at 1, both lanes stay undriven.
- R3: `ub_n` gates bits 15:8 and `lb_n` gates bits 7:0, independently, in writes. A lane whose select is 1 keeps its old stored byte.
- R4: A write is active on an edge only when the chip is selected, `ready` is 1, `we_n` is 0 and at least one of `ub_n`/`lb_n` is 0. With both byte selects at 1, nothing is stored.
- R5: A write ends on the first edge where any of its conditions drops. The address, data and lanes sampled on the last active edge are stored at that ending edge. Earlier data or addresses sampled during the same write are discarded.
- R6: After reset the array holds all zeros and `ready` is 0. `ready` rises after exactly `INIT_CYCLES` edges following reset release and then stays 1. While `ready` is 0, reads drive nothing and writes store nothing.
- R7: `refreshing` becomes 1 only after `GAP_CYCLES` consecutive edges sample the chip deselected (with `ready` at 1). It falls on the edge that samples selection, and it is never 1 together with any `dq_oe` bit.
- R8: `data_lost` is set once `LIMIT_CYCLES` edges pass after `ready` without a refresh. Deselect gaps shorter than `GAP_CYCLES` do not count as refresh.
- R9: `data_lost` is sticky and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| sel_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| ub_n | input | 1 | Active-low upper byte select (bits 15:8) |
| lb_n | input | 1 | Active-low lower byte select (bits 7:0) |
| addr | input | $clog2(DEPTH) | Word address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe | output | 2 | Per-lane drive enable, bit 1 upper, bit 0 lower |
| ready | output | 1 | Start-up period finished |
| refreshing | output | 1 | Hidden refresh in progress |
| data_lost | output | 1 | Sticky refresh-starvation flag |

## Verification
The bench targets the write-ending edge. It changes data and address in the middle of a write, and ends writes by raising write enable or dropping both lanes. A model that captured data at the start of the write would store the first data word or the first address. It then probes single-lane writes and a write with no lane selected; a model that ignored lane gating would overwrite the neighbouring byte. For refresh, it checks the one-edge deselect gap against the two-edge gap. It then starves refresh with selections broken only by one-edge gaps: a scheduler that treated any deselect as a refresh would never raise the loss flag. Finally it confirms that a start-up write leaves the zeroed array untouched, and that the loss flag survives later refreshes until reset.

// File: rtl/psram_pkg.sv
// Shared widths and types for the pseudo-static RAM model.
package psram_pkg;
    localparam int LANES  = 2;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/psram_init_timer.sv
// Start-up timer: holds ready low for INIT_CYCLES edges after reset
// release, then keeps it high. Assumes INIT_CYCLES >= 1.
module psram_init_timer #(
    parameter int INIT_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CW = $clog2(INIT_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Count start-up edges and raise ready on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(INIT_CYCLES - 1)) begin
                ready <= 1'b1;
            end
        end
    end

    p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

// File: rtl/psram_refresh_sched.sv
// Hidden refresh scheduler: refreshes only after GAP_CYCLES consecutive
// deselected edges and flags data loss when LIMIT_CYCLES edges pass
// without a refresh. Assumes GAP_CYCLES >= 1 and LIMIT_CYCLES >= 2.
module psram_refresh_sched #(
    parameter int GAP_CYCLES   = 2,
    parameter int LIMIT_CYCLES = 3750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic selected,
    output logic refreshing,
    output logic data_lost
);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam int LW = $clog2(LIMIT_CYCLES + 1);

    logic [GW-1:0] desel_run;
    logic [LW-1:0] since_refresh;
    logic          refresh_go;

    // A refresh may start once the deselect run has reached the gap.
    always_comb begin
        refresh_go = ready && !selected && (desel_run == GW'(GAP_CYCLES - 1));
    end

    // Track consecutive deselected edges, saturating at the gap length.
    always_ff @(posedge clk) begin
        if (!rst_n || selected) begin
            desel_run <= '0;
        end else if (desel_run != GW'(GAP_CYCLES - 1)) begin
            desel_run <= desel_run + 1'b1;
        end
    end

    // Age since the last refresh, and the sticky starvation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_refresh <= '0;
            refreshing    <= 1'b0;
            data_lost     <= 1'b0;
        end else begin
            refreshing <= refresh_go;
            if (!ready || refresh_go) begin
                since_refresh <= '0;
            end else if (since_refresh != LW'(LIMIT_CYCLES)) begin
                since_refresh <= since_refresh + 1'b1;
            end
            if (ready && !refresh_go && since_refresh == LW'(LIMIT_CYCLES - 1)) begin
                data_lost <= 1'b1;
            end
        end
    end

    p_refresh_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refreshing |-> $past(!selected));
    p_lost_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(data_lost) |-> data_lost);
endmodule

// File: rtl/psram_core.sv
// Storage array with byte-lane write capture and registered reads.
// A write is captured on each active edge and stored at the edge
// where it ends; reads return the array word one edge after sampling.
// Assumes the array is zeroed by reset (small depth).
module psram_core
    import psram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ready,
    input  logic          selected,
    input  logic          we_n,
    input  logic          oe_n,
    input  lane_mask_t    lane_n,
    input  logic [AW-1:0] addr,
    input  word_t         din,
    output word_t         dout,
    output lane_mask_t    dout_en
);
    logic          wr_now;
    logic          wr_q;
    logic          commit;
    logic [AW-1:0] wr_addr_q;
    word_t         wr_data_q;
    lane_mask_t    wr_lane_q;

    // Write is active only with a selected, ready chip and a lane enabled.
    always_comb begin
        wr_now = ready && selected && !we_n && (lane_n != '1);
        commit = wr_q && !wr_now;
    end

    // Hold the most recent address, data and lanes of an active write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
            wr_lane_q <= '0;
        end else begin
            wr_q <= wr_now;
            if (wr_now) begin
                wr_addr_q <= addr;
                wr_data_q <= din;
                wr_lane_q <= ~lane_n;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] mem [DEPTH];
        logic [BYTE_W-1:0] rd_q;
        logic              rd_en;
        logic              en_q;

        always_comb begin
            rd_en = ready && selected && we_n && !oe_n && !lane_n[g];
        end

        // Store this lane's byte at the ending edge of a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < DEPTH; k++) begin
                    mem[k] <= '0;
                end
            end else if (commit && wr_lane_q[g]) begin
                mem[wr_addr_q] <= wr_data_q[g*BYTE_W +: BYTE_W];
            end
        end

        // Register this lane's read byte and its drive enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q <= '0;
                en_q <= 1'b0;
            end else begin
                en_q <= rd_en;
                rd_q <= rd_en ? mem[addr] : '0;
            end
        end

        assign dout[g*BYTE_W +: BYTE_W] = rd_q;
        assign dout_en[g]               = en_q;
    end

    p_nolane_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_n == '1) |=> !wr_q);
endmodule

// File: rtl/psram_model.sv
// Top of the pseudo-static RAM model: combines the chip selects,
// start-up timer, refresh scheduler and byte-lane storage core.
// All inputs are sampled on the rising clock edge; timing is in cycles.
module psram_model #(
    parameter int DEPTH        = 256,
    parameter int CLK_MHZ      = 250,
    parameter int INIT_CYCLES  = 50 * CLK_MHZ,
    parameter int LIMIT_CYCLES = 15 * CLK_MHZ,
    parameter int GAP_CYCLES   = (5 * CLK_MHZ + 999) / 1000,
    localparam int AW          = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          sel_hi,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          ub_n,
    input  logic          lb_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   dq_in,
    output logic [15:0]   dq_out,
    output logic [1:0]    dq_oe,
    output logic          ready,
    output logic          refreshing,
    output logic          data_lost
);
    logic selected;

    // Both chip selects must be active for the chip to be selected.
    always_comb begin
        selected = !sel_n && sel_hi;
    end

    psram_init_timer #(
        .INIT_CYCLES(INIT_CYCLES)
    ) u_init (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    psram_refresh_sched #(
        .GAP_CYCLES  (GAP_CYCLES),
        .LIMIT_CYCLES(LIMIT_CYCLES)
    ) u_refresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .selected  (selected),
        .refreshing(refreshing),
        .data_lost (data_lost)
    );

    psram_core #(
        .DEPTH(DEPTH),
        .AW   (AW)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready   (ready),
        .selected(selected),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .lane_n  ({ub_n, lb_n}),
        .addr    (addr),
        .din     (dq_in),
        .dout    (dq_out),
        .dout_en (dq_oe)
    );

    p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !selected |=> (dq_oe == 2'b00));
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refreshing |-> (dq_oe == 2'b00));
    p_init_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (dq_oe == 2'b00));
endmodule

// File: tb/psram_model_bench.sv
module psram_model_bench;
    localparam int DEPTH = 16;
    localparam int INIT  = 40;
    localparam int LIMIT = 100;
    localparam int GAP   = 2;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          sel_hi = 1'b0;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic          ub_n = 1'b1;
    logic          lb_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out;
    logic [1:0]    dq_oe;
    logic          ready;
    logic          refreshing;
    logic          data_lost;

    int checks = 0;
    int fails  = 0;

    psram_model #(
        .DEPTH(DEPTH), .CLK_MHZ(250), .INIT_CYCLES(INIT),
        .LIMIT_CYCLES(LIMIT), .GAP_CYCLES(GAP)
    ) u_psram_model (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_hi(sel_hi),
        .oe_n(oe_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .ready(ready), .refreshing(refreshing), .data_lost(data_lost)
    );

    initial forever #2 clk = ~clk;

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        sel_n = 1'b1; sel_hi = 1'b1; we_n = 1'b1; oe_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1;
    endtask

    task automatic drive_sel(input logic [AW-1:0] a);
        sel_n = 1'b0; sel_hi = 1'b1; addr = a;
    endtask

    task automatic write_word(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] lanes_n);
        drive_sel(a); we_n = 1'b0; oe_n = 1'b1; {ub_n, lb_n} = lanes_n; dq_in = d;
        cyc();
        idle();
        cyc();
    endtask

    task automatic read_check(input logic [AW-1:0] a, input logic [1:0] lanes_n,
                              input logic [1:0] exp_oe, input logic [15:0] exp_d, input string req);
        drive_sel(a); we_n = 1'b1; oe_n = 1'b0; {ub_n, lb_n} = lanes_n;
        cyc();
        chk({14'd0, dq_oe}, {14'd0, exp_oe}, req);
        if (exp_oe[1]) chk({8'd0, dq_out[15:8]}, {8'd0, exp_d[15:8]}, req);
        if (exp_oe[0]) chk({8'd0, dq_out[7:0]}, {8'd0, exp_d[7:0]}, req);
        idle();
        cyc();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle();
        repeat (3) cyc();
        chk({14'd0, dq_oe}, 16'd0, "R6 reset oe");
        chk({15'd0, ready}, 16'd0, "R6 reset ready");
        chk({15'd0, refreshing}, 16'd0, "R7 reset refreshing");
        chk({15'd0, data_lost}, 16'd0, "R9 reset lost");
    endtask

    task automatic t_init();
        rst_n = 1'b1;
        drive_sel(AW'(9)); we_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0; dq_in = 16'hFFFF;
        repeat (3) cyc();
        we_n = 1'b1; oe_n = 1'b0;
        cyc();
        chk({14'd0, dq_oe}, 16'd0, "R6 no read during init");
        idle();
        repeat (INIT - 5) cyc();
        chk({15'd0, ready}, 16'd0, "R6 ready still low");
        cyc();
        chk({15'd0, ready}, 16'd1, "R6 ready after INIT edges");
        read_check(AW'(9), 2'b00, 2'b11, 16'h0000, "R6 init write ignored");
    endtask

    task automatic t_rw();
        write_word(AW'(3), 16'hA5C3, 2'b00);
        read_check(AW'(3), 2'b00, 2'b11, 16'hA5C3, "R2 full word read");
        read_check(AW'(3), 2'b10, 2'b01, 16'hA5C3, "R2 lower lane only");
        read_check(AW'(3), 2'b01, 2'b10, 16'hA5C3, "R2 upper lane only");
        drive_sel(AW'(3)); we_n = 1'b1; oe_n = 1'b1; ub_n = 1'b0; lb_n = 1'b0;
        cyc();
        chk({14'd0, dq_oe}, 16'd0, "R2 oe_n high no drive");
        idle(); cyc();
    endtask

    task automatic t_bytes();
        write_word(AW'(3), 16'h11EE, 2'b01);
        read_check(AW'(3), 2'b00, 2'b11, 16'h11C3, "R3 upper-only write");
        write_word(AW'(3), 16'h2277, 2'b10);
        read_check(AW'(3), 2'b00, 2'b11, 16'h1177, "R3 lower-only write");
    endtask

    task automatic t_nolane();
        drive_sel(AW'(3)); we_n = 1'b0; ub_n = 1'b1; lb_n = 1'b1; dq_in = 16'hFFFF;
        repeat (2) cyc();
        idle(); cyc();
        read_check(AW'(3), 2'b00, 2'b11, 16'h1177, "R4 no-lane write ignored");
    endtask

    task automatic t_desel();
        sel_n = 1'b0; sel_hi = 1'b0; addr = AW'(3); we_n = 1'b1; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
        cyc();
        chk({14'd0, dq_oe}, 16'd0, "R1 sel_hi low no drive");
        sel_n = 1'b1; sel_hi = 1'b1;
        cyc();
        chk({14'd0, dq_oe}, 16'd0, "R1 sel_n high no drive");
        sel_n = 1'b0; sel_hi = 1'b0; we_n = 1'b0; oe_n = 1'b1; dq_in = 16'hDEAD;
        repeat (2) cyc();
        idle(); cyc();
        read_check(AW'(3), 2'b00, 2'b11, 16'h1177, "R1 deselected write ignored");
    endtask

    task automatic t_end_edge();
        drive_sel(AW'(5)); we_n = 1'b0; oe_n = 1'b1; ub_n = 1'b0; lb_n = 1'b0;
        dq_in = 16'h1111; cyc();
        dq_in = 16'h2222; cyc();
        dq_in = 16'h3333; cyc();
        we_n = 1'b1; dq_in = 16'h4444; cyc();
        idle(); cyc();
        read_check(AW'(5), 2'b00, 2'b11, 16'h3333, "R5 end by we_n");
        drive_sel(AW'(6)); we_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
        dq_in = 16'h4444; cyc();
        dq_in = 16'h5555; cyc();
        ub_n = 1'b1; lb_n = 1'b1; dq_in = 16'h6666; cyc();
        idle(); cyc();
        read_check(AW'(6), 2'b00, 2'b11, 16'h5555, "R5 end by lanes");
        drive_sel(AW'(7)); we_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
        dq_in = 16'h6666; cyc();
        addr = AW'(8); cyc();
        idle(); cyc();
        read_check(AW'(8), 2'b00, 2'b11, 16'h6666, "R5 last address used");
        read_check(AW'(7), 2'b00, 2'b11, 16'h0000, "R5 first address untouched");
    endtask

    task automatic t_refresh();
        drive_sel(AW'(3)); we_n = 1'b1; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
        cyc();
        chk({15'd0, refreshing}, 16'd0, "R7 no refresh while selected");
        idle(); cyc();
        chk({15'd0, refreshing}, 16'd0, "R7 one-edge gap too short");
        cyc();
        chk({15'd0, refreshing}, 16'd1, "R7 refresh after gap");
        drive_sel(AW'(3)); we_n = 1'b1; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
        cyc();
        chk({15'd0, refreshing}, 16'd0, "R7 refresh drops on select");
        chk({14'd0, dq_oe}, 16'd3, "R7 access served after refresh");
        idle(); cyc();
    endtask

    task automatic t_lost();
        idle(); repeat (3) cyc();
        drive_sel(AW'(3)); we_n = 1'b1; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
        repeat (LIMIT - 10) cyc();
        idle(); repeat (5) cyc();
        chk({15'd0, data_lost}, 16'd0, "R8 select under limit keeps data");
        begin
            int overlap = 0;
            for (int i = 0; i < 60; i++) begin
                drive_sel(AW'(3)); we_n = 1'b1; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
                cyc();
                if (refreshing) overlap++;
                idle();
                cyc();
                if (refreshing) overlap++;
            end
            chk(16'(overlap), 16'd0, "R8 short gaps give no refresh");
        end
        chk({15'd0, data_lost}, 16'd1, "R8 starved refresh flags loss");
        idle(); repeat (10) cyc();
        chk({15'd0, refreshing}, 16'd1, "R9 refresh resumes");
        chk({15'd0, data_lost}, 16'd1, "R9 loss stays set");
        rst_n = 1'b0; repeat (2) cyc();
        rst_n = 1'b1; cyc();
        chk({15'd0, data_lost}, 16'd0, "R9 reset clears loss");
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_init();
        t_rw();
        t_bytes();
        t_nolane();
        t_desel();
        t_end_edge();
        t_refresh();
        t_lost();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule